// File: doc/BRIEF.md
# Tile Delta Color Compressor

This block compresses one 8x8 tile of 32-bit pixels, each holding four 8-bit integer channels. Pixels arrive one per handshake in raster order and are buffered inside the block. Pixel 0 becomes the base, and every channel of every later pixel is stored as a signed difference from the same channel of the base. The widest of these differences across the tile decides which compression class the tile starts from. If the packed payload is too large for that class, the class grows step by step until the payload fits, or the tile is stored raw.

After the 64th pixel is accepted the block stops taking input. It then emits the tile as 32-byte beats, each carrying the class code, and the last beat is flagged. A tile whose pixels all equal a programmed clear color produces a single empty beat with the cleared code. Pixel formats other than 8-bit integer per channel are stored raw. A memory-side agent uses the code to size the read of a slot that always starts on a 256-byte boundary.

Top module: `tile_delta_compressor`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: The block accepts exactly 64 pixels per tile (handshake `in_valid && in_ready`). From the cycle after the 64th is accepted, `in_ready` stays 0 until the final output beat of that tile has been taken.
- R3: Each channel delta is the two's complement difference (pixel minus base, over 9 signed bits), with pixel 0 as the base. Its width is the fewest signed bits that hold it, and a delta of 0 has width 1. The tile width W is the maximum over all pixels and channels. W of 2 or less starts at class 8:1, W=3 at 4:1, W=4 at 2:1, and wider goes to 1:1.
- R4: Deltas are packed at width P = max(W,2), so a payload takes 32 + 252*P bits. Class capacities are 256 bits (8:1), 512 (4:1) and 1024 (2:1). Starting at the chosen class, the block moves to the next larger class while the payload exceeds capacity, and ends at 1:1 (raw) if no class fits. As a result W<=3 gives 2:1 and W=4 gives 1:1.
- R5: `out_code` is 0 for cleared, 1 for 8:1, 2 for 4:1, 3 for 2:1 and 4 for 1:1. These emit 1, 1, 2, 4 and 8 beats in that order, and `out_last` is 1 exactly on the final beat.
- R6: The compressed payload is a little-endian bit stream. Bits [31:0] hold the base pixel. The P-bit delta of pixel p (1..63), channel c (0..3, where channel c sits in pixel bits [8c+7:8c]) starts at bit 32 + ((p-1)*4 + c)*P. Unused bits are zero, and beat k carries stream bits [256k+255:256k].
- R7: In a raw tile, beat k carries pixels 8k..8k+7, with pixel 8k in bits [31:0].
- R8: `fmt_int8` is sampled with pixel 0. When it is 0, a tile that is not cleared is emitted raw whatever its deltas are.
- R9: If all 64 pixels equal `clear_color` (sampled on each accepted pixel), the tile emits one beat with code 0, `out_empty`=1, `out_last`=1 and zero data. This applies whatever `fmt_int8` is.
- R10: While `out_valid` is 1 and `out_ready` is 0, the block holds `out_valid`, `out_data`, `out_code`, `out_last` and `out_empty` unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_int8 | input | 1 | Tile format is 8-bit integer per channel (sampled with pixel 0) |
| clear_color | input | 32 | Color that marks a cleared tile |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_pix | input | 32 | Input pixel, channel c in bits [8c+7:8c] |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | 256 | Payload beat |
| out_code | output | 3 | Class code of the tile |
| out_last | output | 1 | Final beat of the tile |
| out_empty | output | 1 | Beat carries no payload (cleared tile) |

## Verification
The assertions assume a downstream that eventually raises `out_ready` and a `fmt_int8` that is valid whenever pixel 0 is offered. The stimulus holds `fmt_int8` steady for the whole tile and changes `out_ready` only just after a clock edge, following a fixed stall pattern. The stall checks compare each beat held under backpressure with the value seen one cycle earlier. Input gaps are inserted at fixed pixel positions, so the buffering behaves the same whether pixels arrive back to back or spaced out.

// File: rtl/tdc_pkg.sv
package tdc_pkg;

    typedef enum logic [2:0] {
        CODE_CLEAR = 3'd0,
        CODE_R8    = 3'd1,
        CODE_R4    = 3'd2,
        CODE_R2    = 3'd3,
        CODE_RAW   = 3'd4
    } tdc_code_e;

    // capacity in bits of a compressed class (codes 1..3)
    function automatic int unsigned cap_bits(input int unsigned beat_w, input logic [2:0] code);
        if (code == 3'd0) return 0;
        return beat_w << (code - 3'd1);
    endfunction

    // bits used by base plus all packed deltas at width w
    function automatic int unsigned pack_bits(input int unsigned pix_w, input int unsigned npix,
                                              input int unsigned nch, input int unsigned w);
        return pix_w + (npix - 1) * nch * w;
    endfunction

    function automatic int unsigned beats_of(input logic [2:0] code);
        if (code == 3'd0) return 1;
        return 1 << (code - 3'd1);
    endfunction

    // fewest signed bits holding d, searched downward from maxw
    function automatic int unsigned signed_width(input int d, input int unsigned maxw);
        int unsigned r;
        r = maxw;
        for (int unsigned w = maxw; w >= 1; w--) begin
            if ((d >= -(1 <<< (w - 1))) && (d <= (1 <<< (w - 1)) - 1)) r = w;
        end
        return r;
    endfunction

endpackage

// File: rtl/tdc_width.sv
module tdc_width #(
    parameter  int CH_W  = 8,
    parameter  int NCH   = 4,
    localparam int PIX_W = CH_W * NCH,
    localparam int WW    = $clog2(CH_W + 2)
) (
    input  logic [PIX_W-1:0] pix,
    input  logic [PIX_W-1:0] base,
    output logic [WW-1:0]    width
);
    import tdc_pkg::*;

    logic [WW-1:0] ch_w [NCH];

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        always_comb begin
            ch_w[c] = WW'(signed_width(int'(pix[c*CH_W +: CH_W]) - int'(base[c*CH_W +: CH_W]),
                                       CH_W + 1));
        end
    end

    always_comb begin
        width = ch_w[0];
        for (int c = 1; c < NCH; c++) begin
            if (ch_w[c] > width) width = ch_w[c];
        end
    end

endmodule

// File: rtl/tdc_packer.sv
module tdc_packer #(
    parameter  int CH_W      = 8,
    parameter  int NCH       = 4,
    parameter  int NPIX      = 64,
    localparam int PIX_W     = CH_W * NCH,
    localparam int TILE_BITS = NPIX * PIX_W
) (
    input  logic [TILE_BITS-1:0] tile,
    input  logic [1:0]           wsel,
    output logic [TILE_BITS-1:0] payload
);
    // one packed image per delta width 2, 3 and 4
    for (genvar g = 0; g < 3; g++) begin : g_w
        localparam int W = g + 2;
        logic [TILE_BITS-1:0] pk;
        logic [CH_W-1:0]      diff;
        always_comb begin
            pk            = '0;
            diff          = '0;
            pk[PIX_W-1:0] = tile[PIX_W-1:0];
            for (int p = 1; p < NPIX; p++) begin
                for (int c = 0; c < NCH; c++) begin
                    diff = tile[p*PIX_W + c*CH_W +: CH_W] - tile[c*CH_W +: CH_W];
                    pk[PIX_W + ((p-1)*NCH + c)*W +: W] = diff[W-1:0];
                end
            end
        end
    end

    always_comb begin
        case (wsel)
            2'd0:    payload = g_w[0].pk;
            2'd1:    payload = g_w[1].pk;
            default: payload = g_w[2].pk;
        endcase
    end

endmodule

// File: rtl/tile_delta_compressor.sv
module tile_delta_compressor #(
    parameter  int CH_W      = 8,
    parameter  int NCH       = 4,
    parameter  int TILE_DIM  = 8,
    parameter  int BEAT_W    = 256,
    localparam int PIX_W     = CH_W * NCH,
    localparam int NPIX      = TILE_DIM * TILE_DIM,
    localparam int TILE_BITS = NPIX * PIX_W,
    localparam int IDX_W     = $clog2(NPIX),
    localparam int NBEAT     = TILE_BITS / BEAT_W,
    localparam int BI_W      = $clog2(NBEAT),
    localparam int WW        = $clog2(CH_W + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_int8,
    input  logic [PIX_W-1:0]  clear_color,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [PIX_W-1:0]  in_pix,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [BEAT_W-1:0] out_data,
    output logic [2:0]        out_code,
    output logic              out_last,
    output logic              out_empty
);
    import tdc_pkg::*;

    typedef struct packed {
        logic                 emit;
        logic [IDX_W-1:0]     idx;
        logic [WW-1:0]        maxw;
        logic                 all_clr;
        logic                 fmt;
        tdc_code_e            code;
        logic [1:0]           wsel;
        logic [BI_W-1:0]      beat;
        logic [TILE_BITS-1:0] tile;
    } st_t;

    st_t q, d;

    logic [PIX_W-1:0]     base;
    logic [WW-1:0]        pix_w;
    logic [TILE_BITS-1:0] payload;
    logic                 last_beat;

    assign base = (q.idx == '0) ? in_pix : q.tile[PIX_W-1:0];

    tdc_width #(.CH_W(CH_W), .NCH(NCH)) u_width (
        .pix   (in_pix),
        .base  (base),
        .width (pix_w)
    );

    tdc_packer #(.CH_W(CH_W), .NCH(NCH), .NPIX(NPIX)) u_pack (
        .tile    (q.tile),
        .wsel    (q.wsel),
        .payload (payload)
    );

    assign last_beat = (32'(q.beat) == beats_of(q.code) - 1);

    always_comb begin
        logic          first, clr, fm, found;
        logic [WW-1:0] mw, pw;
        logic [2:0]    start;
        d     = q;
        first = (q.idx == '0);
        clr   = 1'b0;
        fm    = 1'b0;
        found = 1'b0;
        mw    = '0;
        pw    = '0;
        start = 3'd0;
        if (in_valid && !q.emit) begin
            d.tile[q.idx*PIX_W +: PIX_W] = in_pix;
            mw  = (first || pix_w > q.maxw) ? pix_w : q.maxw;
            clr = (in_pix == clear_color) && (first || q.all_clr);
            fm  = first ? fmt_int8 : q.fmt;
            d.maxw    = mw;
            d.all_clr = clr;
            d.fmt     = fm;
            d.idx     = q.idx + 1'b1;
            if (q.idx == IDX_W'(NPIX - 1)) begin
                d.emit = 1'b1;
                d.beat = '0;
                pw     = (mw <= WW'(2)) ? WW'(2) : mw;
                d.wsel = (pw <= WW'(4)) ? 2'(pw - WW'(2)) : 2'd2;
                start  = (mw <= WW'(2)) ? 3'd1 : (mw == WW'(3)) ? 3'd2 : 3'd3;
                d.code = CODE_RAW;
                if (clr) begin
                    d.code = CODE_CLEAR;
                end else if (fm && mw <= WW'(4)) begin
                    for (int c = 1; c <= 3; c++) begin
                        if (!found && 3'(c) >= start &&
                            pack_bits(PIX_W, NPIX, NCH, 32'(pw)) <= cap_bits(BEAT_W, 3'(c))) begin
                            found  = 1'b1;
                            d.code = tdc_code_e'(3'(c));
                        end
                    end
                end
            end
        end
        if (q.emit && out_ready) begin
            if (last_beat) d.emit = 1'b0;
            else           d.beat = q.beat + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        in_ready  = !q.emit;
        out_valid = q.emit;
        out_code  = q.code;
        out_last  = q.emit && last_beat;
        out_empty = q.emit && (q.code == CODE_CLEAR);
        if (!q.emit || q.code == CODE_CLEAR) out_data = '0;
        else if (q.code == CODE_RAW)         out_data = q.tile[q.beat*BEAT_W +: BEAT_W];
        else                                 out_data = payload[q.beat*BEAT_W +: BEAT_W];
    end

    // ---------------- assertions ----------------
    AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_code)
                                    && $stable(out_last)) else $error("hold");   // R10
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_code <= 3'd4) else $error("code");   // R5
    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_code == 3'd0 |-> out_empty && out_last && out_data == '0) else $error("clr");   // R9
    AST_FMT_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !q.fmt && out_code != 3'd0 |-> out_code == 3'd4) else $error("fmt");   // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_code inside {3'd1, 3'd2, 3'd3}
        |-> pack_bits(PIX_W, NPIX, NCH, 32'(q.wsel) + 2) <= cap_bits(BEAT_W, out_code)) else $error("ovf");   // R4
    AST_NO_INTAKE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && in_valid |=> $stable(q.idx)) else $error("intake");   // R2
    AST_LAST_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid && in_ready) else $error("last");   // R5

endmodule

// File: tb/tile_delta_compressor_tb.sv
module tile_delta_compressor_tb;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         fmt_int8 = 1'b1;
    logic [31:0]  clear_color = 32'hA5A5_5A5A;
    logic         in_valid = 1'b0;
    logic         in_ready;
    logic [31:0]  in_pix = '0;
    logic         out_valid;
    logic         out_ready = 1'b0;
    logic [255:0] out_data;
    logic [2:0]   out_code;
    logic         out_last;
    logic         out_empty;

    always #2.5 clk = ~clk;

    tile_delta_compressor u_dut (
        .clk(clk), .rst_n(rst_n), .fmt_int8(fmt_int8), .clear_color(clear_color),
        .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_code(out_code), .out_last(out_last), .out_empty(out_empty)
    );

    typedef struct {
        logic [255:0] data;
        logic [2:0]   code;
        logic         last;
        logic         empty;
        string        req;
    } item_t;

    item_t        exp_q[$];
    int           checks = 0;
    int           errors = 0;
    int           cyc = 0;
    logic [31:0]  t [64];
    logic [31:0]  lfsr = 32'h1357_9BDF;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int bits_of(input int dv);
        int m, b;
        m = (dv < 0) ? -dv - 1 : dv;
        b = 1;
        while (m > 0) begin b++; m = m >> 1; end
        return b;
    endfunction

    function automatic logic [31:0] rnd();
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        return lfsr;
    endfunction

    // model: compute expected beats of tile t and queue them
    task automatic expect_tile(input bit fmt, input string req);
        int w, pw, cls, nb, pos, dv;
        bit clr;
        logic [2047:0] stream;
        item_t it;
        w = 1; clr = 1;
        for (int p = 0; p < 64; p++) begin
            if (t[p] != clear_color) clr = 0;
            for (int c = 0; c < 4; c++) begin
                dv = int'(t[p][8*c +: 8]) - int'(t[0][8*c +: 8]);
                if (bits_of(dv) > w) w = bits_of(dv);
            end
        end
        pw = (w < 2) ? 2 : w;
        if (clr) cls = 0;
        else if (!fmt || w > 4) cls = 4;
        else begin
            cls = (w <= 2) ? 1 : (w == 3) ? 2 : 3;
            while (cls < 4 && 32 + 252 * pw > (256 << (cls - 1))) cls++;
        end
        stream = '0;
        if (cls == 4) begin
            for (int p = 0; p < 64; p++) stream[32*p +: 32] = t[p];
        end else if (cls != 0) begin
            stream[31:0] = t[0];
            for (int p = 1; p < 64; p++)
                for (int c = 0; c < 4; c++) begin
                    dv  = int'(t[p][8*c +: 8]) - int'(t[0][8*c +: 8]);
                    pos = 32 + ((p - 1) * 4 + c) * pw;
                    for (int b = 0; b < pw; b++) stream[pos + b] = dv[b];
                end
        end
        nb = (cls == 0) ? 1 : (1 << (cls - 1));
        for (int k = 0; k < nb; k++) begin
            it.data  = stream[256*k +: 256];
            it.code  = 3'(cls);
            it.last  = (k == nb - 1);
            it.empty = (cls == 0);
            it.req   = req;
            exp_q.push_back(it);
        end
    endtask

    task automatic drive_tile(input bit fmt, input string req);
        expect_tile(fmt, req);
        for (int i = 0; i < 64; i++) begin
            if (i % 9 == 4) begin
                @(negedge clk);
                in_valid = 1'b0;
            end
            forever begin
                @(negedge clk);
                in_valid = 1'b1;
                in_pix   = t[i];
                fmt_int8 = fmt;
                if (in_ready) break;
            end
            @(posedge clk);
        end
        @(negedge clk);
        in_valid = 1'b0;
        // R2: intake closed while the tile is emitted
        check(in_ready == 1'b0, "R2", "in_ready after 64th pixel", 256'(in_ready), 256'(0));
        wait (exp_q.size() == 0);
        @(negedge clk);
        check(in_ready == 1'b1, "R2", "in_ready after last beat", 256'(in_ready), 256'(1));
    endtask

    // tile with each channel delta drawn from [lo, hi]
    task automatic fill_small(input logic [31:0] b, input int lo, input int hi);
        int v;
        t[0] = b;
        for (int p = 1; p < 64; p++)
            for (int c = 0; c < 4; c++) begin
                v = lo + int'(rnd() % 32'(hi - lo + 1));
                t[p][8*c +: 8] = 8'(int'(b[8*c +: 8]) + v);
            end
    endtask

    // stall pattern changes just after the edge
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 out_ready <= ((cyc % 5) != 2);
    end

    // monitor / scoreboard
    logic         stalled = 1'b0;
    logic [255:0] hold_d;
    logic [2:0]   hold_c;
    always @(negedge clk) begin
        if (rst_n) begin
            if (stalled) begin
                check(out_valid && out_data == hold_d && out_code == hold_c, "R10",
                      "held beat", out_data, hold_d);
            end
            stalled = out_valid && !out_ready;
            hold_d  = out_data;
            hold_c  = out_code;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R2", "unexpected beat", 256'(out_code), 256'(0));
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check(out_code == e.code, e.req, "code", 256'(out_code), 256'(e.code));
                    check(out_last == e.last, "R5", "last", 256'(out_last), 256'(e.last));
                    check(out_empty == e.empty, "R9", "empty", 256'(out_empty), 256'(e.empty));
                    check(out_data == e.data, e.req, "data", out_data, e.data);
                end
            end
        end
    end

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 256'(0), 256'(1));
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "out_valid after reset", 256'(out_valid), 256'(0));
        check(in_ready == 1'b1, "R1", "in_ready after reset", 256'(in_ready), 256'(1));

        // flat tile: W=1, 8:1 and 4:1 overflow, lands at 2:1 (R3 R4 R6)
        for (int p = 0; p < 64; p++) t[p] = 32'h1122_3344;
        drive_tile(1'b1, "R4");
        // deltas in [-2,1]: W=2, packed at 2 bits (R6)
        fill_small(32'h8080_8080, -2, 1);
        drive_tile(1'b1, "R6");
        // deltas in [-4,3]: W=3 boundary, still 2:1 (R3)
        fill_small(32'h4060_80A0, -4, 3);
        t[5] = t[0] + 32'h0000_0003;
        t[6] = t[0] - 32'h0000_0004;
        drive_tile(1'b1, "R3");
        // one delta of +4 makes W=4, 2:1 overflows to raw (R4 R7)
        fill_small(32'h4060_80A0, -4, 3);
        t[63][15:8] = t[0][15:8] + 8'd4;
        drive_tile(1'b1, "R4");
        // delta -8 in channel 3 only: W=4, raw (R3)
        fill_small(32'h7070_7070, 0, 0);
        t[20][31:24] = t[0][31:24] - 8'd8;
        drive_tile(1'b1, "R3");
        // wide random tile: raw layout (R7)
        for (int p = 0; p < 64; p++) t[p] = rnd();
        drive_tile(1'b1, "R7");
        // flat tile with non-integer format: raw (R8)
        for (int p = 0; p < 64; p++) t[p] = 32'h0102_0304;
        drive_tile(1'b0, "R8");
        // cleared tile (R9), and again with non-integer format
        for (int p = 0; p < 64; p++) t[p] = clear_color;
        drive_tile(1'b1, "R9");
        drive_tile(1'b0, "R9");
        // clear color everywhere except last pixel: not cleared, deltas W=2 (R9)
        t[63] = clear_color + 32'h0000_0001;
        drive_tile(1'b1, "R9");
        // small negative deltas packed at 2 bits across all channels (R6)
        fill_small(32'h0000_00FF, -1, 0);
        t[0] = 32'h0101_0101;
        fill_small(32'h0101_0101, -2, 1);
        drive_tile(1'b1, "R6");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule